// File: doc/BRIEF.md
# Fault Isolation Register Bank

This block keeps the error-tracking state of one subsystem in a bank of 64-bit words reached through a simple configuration port. A fault word collects error events. A mask word hides the events that should not raise attention. Two action words hold the response selection for each fault bit. A small set of control and view words sits beside them. Hardware raises fault bits with single-cycle pulses on a fault input vector. Software reads the words, clears handled faults, and adjusts the mask.

Software can change single bits without a read-modify-write sequence. Each of the fault and mask words has three addresses: a direct one that replaces the word, a clear alias that ANDs the written data into the word, and a set alias that ORs the data into it. A first-error word holds the fault pulse vector that first arrived while it was empty. Any write returns it to zero. A single attention output tells the surrounding logic that some fault bit is set and not masked.

Top module: `fault_reg_bank`

## Requirements
- R1: The word index is the byte address shifted right by three. An access is accepted only when all eight byte enables are set and address bits 2:0 are zero. A rejected write changes nothing, a rejected read returns all ones, and either kind raises `size_err` for the one cycle after the request.
- R2: An accepted write to index 0 replaces the fault word with the write data.
- R3: A write to index 1 ANDs the data into the fault word. A write to index 2 ORs the data into it.
- R4: The mask word is replaced by a write to index 3, ANDed by a write to index 4 and ORed by a write to index 5.
- R5: Indices 6 and 7 are plain read/write action words that keep all 64 bits.
- R6: The first-error word (index 8) loads the fault input vector when it holds zero and that vector is non-zero. Otherwise any write to index 8 clears it. A capture that arrives while the word holds zero wins over a clear write in the same cycle.
- R7: A write to the mode word (index 9) keeps only bits 63:56 and zeroes the rest. A write to the reset-control word (index 10) keeps only bit 63.
- R8: Index 11 reads the unmasked fault vector (fault AND NOT mask). Index 12 reads a status word with attention in bit 63, "first-error non-zero" in bit 62, and zeros elsewhere. Writes to either index change no state.
- R9: A bit of `hw_fault` that is high for a cycle sets the matching fault bit at that clock edge. The pulse wins over a software write to the fault word in the same cycle.
- R10: `attn` is high exactly when some fault bit is set whose mask bit is clear. It follows the stored words with no extra delay.
- R11: A write to an index above 12 changes no state and raises `unimpl` for the one cycle after the request. A read of such an index returns zero.
- R12: A read returns its data on `rd_data` with `rd_valid` high in the cycle after the request. Reads of indices 1 and 2 return the fault word, and reads of indices 4 and 5 return the mask word.
- R13: After reset every stored word is zero, and `attn`, `rd_valid`, `unimpl` and `size_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Access request this cycle |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | ADDR_W | Byte address |
| cfg_be | input | DATA_W/8 | Byte enables; all must be set |
| cfg_wdata | input | DATA_W | Write data |
| hw_fault | input | DATA_W | Single-cycle fault pulses, one per fault bit |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data |
| attn | output | 1 | Some unmasked fault bit is set |
| unimpl | output | 1 | Pulse: write to an unimplemented index |
| size_err | output | 1 | Pulse: access was not a full aligned word |

## Verification
The fault word can be changed by a software write (replace, clear alias or set alias) and by a hardware fault pulse in the same clock cycle. The first-error word can likewise see a capture and a clearing write together. The bench provokes these collisions directly, for example by writing zero to the fault word while a pulse is high, and also places sparse random pulses under random write traffic. After each cycle it compares `attn` and later read-backs with a model in which the pulse bits are ORed in after the software operation, and in which a capture into an empty first-error word takes precedence over its clear.

// File: rtl/fbk_pkg.sv
// Shared definitions for the fault register bank: word indices,
// update operations and the decoded write-strobe bundle.
// Assumes a word-indexed map; index values are fixed by the bank layout.
package fbk_pkg;

    localparam int IDX_FAULT     = 0;
    localparam int IDX_FAULT_AND = 1;
    localparam int IDX_FAULT_OR  = 2;
    localparam int IDX_MASK      = 3;
    localparam int IDX_MASK_AND  = 4;
    localparam int IDX_MASK_OR   = 5;
    localparam int IDX_ACT0      = 6;
    localparam int IDX_ACT1      = 7;
    localparam int IDX_FIRST     = 8;
    localparam int IDX_MODE      = 9;
    localparam int IDX_RSTCTL    = 10;
    localparam int IDX_UNMASKED  = 11;
    localparam int IDX_STATUS    = 12;
    localparam int IDX_LAST      = IDX_STATUS;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_LOAD = 2'd1,
        OP_AND  = 2'd2,
        OP_OR   = 2'd3
    } upd_op_e;

    typedef struct packed {
        upd_op_e fault_op;
        upd_op_e mask_op;
        logic    act0_we;
        logic    act1_we;
        logic    first_clr;
        logic    mode_we;
        logic    rstctl_we;
        logic    unimpl;
    } wr_dec_t;

endpackage

// File: rtl/fbk_decode.sv
// Write decoder: turns an accepted write and its word index into
// per-register strobes and alias operations.
// Assumes wr_en is already qualified by the full-word access check.
module fbk_decode
    import fbk_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    output wr_dec_t          dec
);

    // Purpose: map the index to exactly one strobe or operation.
    always_comb begin
        dec = '0;
        if (wr_en) begin
            case (int'(idx))
                IDX_FAULT:     dec.fault_op  = OP_LOAD;
                IDX_FAULT_AND: dec.fault_op  = OP_AND;
                IDX_FAULT_OR:  dec.fault_op  = OP_OR;
                IDX_MASK:      dec.mask_op   = OP_LOAD;
                IDX_MASK_AND:  dec.mask_op   = OP_AND;
                IDX_MASK_OR:   dec.mask_op   = OP_OR;
                IDX_ACT0:      dec.act0_we   = 1'b1;
                IDX_ACT1:      dec.act1_we   = 1'b1;
                IDX_FIRST:     dec.first_clr = 1'b1;
                IDX_MODE:      dec.mode_we   = 1'b1;
                IDX_RSTCTL:    dec.rstctl_we = 1'b1;
                IDX_UNMASKED, IDX_STATUS: ;
                default:       dec.unimpl    = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/fbk_alias_reg.sv
// Register with replace / AND / OR update and an OR-in set vector that
// takes priority over the software operation.
// Assumes set_vec is zero when no hardware source is attached.
module fbk_alias_reg
    import fbk_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  upd_op_e      op,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] set_vec,
    output logic [W-1:0] q
);

    logic [W-1:0] sw_next;

    // Purpose: apply the software operation to the current value.
    always_comb begin
        case (op)
            OP_LOAD: sw_next = wdata;
            OP_AND:  sw_next = q & wdata;
            OP_OR:   sw_next = q | wdata;
            default: sw_next = q;
        endcase
    end

    // Purpose: store the result with hardware set bits ORed last.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= sw_next | set_vec;
    end

endmodule

// File: rtl/fbk_keep_reg.sv
// Plain write register that stores only the bits selected by KEEP.
// Assumes we is a single-cycle qualified strobe.
module fbk_keep_reg #(
    parameter int           W    = 64,
    parameter logic [W-1:0] KEEP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    // Purpose: load the kept bits of the write data on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata & KEEP;
    end

endmodule

// File: rtl/fbk_first_err.sv
// First-error capture: loads the pulse vector when empty, clears on
// any write; a capture into an empty word beats a same-cycle clear.
// Assumes pulses are single-cycle.
module fbk_first_err #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] pulse,
    output logic [W-1:0] q
);

    logic empty;
    assign empty = (q == '0);

    // Purpose: capture first pulse vector, else honour the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                     q <= '0;
        else if (empty && pulse != '0)  q <= pulse;
        else if (clr)                   q <= '0;
    end

endmodule

// File: rtl/fbk_read_mux.sv
// Read selector: returns the word addressed by the index, including
// alias reads and the two derived view words.
// Assumes attn is consistent with fault and mask.
module fbk_read_mux
    import fbk_pkg::*;
#(
    parameter int W     = 64,
    parameter int IDX_W = 9
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [W-1:0]     fault,
    input  logic [W-1:0]     mask,
    input  logic [W-1:0]     act0,
    input  logic [W-1:0]     act1,
    input  logic [W-1:0]     first,
    input  logic [W-1:0]     mode,
    input  logic [W-1:0]     rstctl,
    input  logic             attn,
    output logic [W-1:0]     data
);

    logic [W-1:0] status_w;
    assign status_w = {attn, (first != '0), {(W-2){1'b0}}};

    // Purpose: select the read word for the index.
    always_comb begin
        case (int'(idx))
            IDX_FAULT, IDX_FAULT_AND, IDX_FAULT_OR: data = fault;
            IDX_MASK, IDX_MASK_AND, IDX_MASK_OR:    data = mask;
            IDX_ACT0:     data = act0;
            IDX_ACT1:     data = act1;
            IDX_FIRST:    data = first;
            IDX_MODE:     data = mode;
            IDX_RSTCTL:   data = rstctl;
            IDX_UNMASKED: data = fault & ~mask;
            IDX_STATUS:   data = status_w;
            default:      data = '0;
        endcase
    end

endmodule

// File: rtl/fault_reg_bank.sv
// Fault isolation register bank. Holds fault, mask, action, first-error,
// mode and reset-control words behind a word-indexed port that accepts
// only full aligned accesses, and raises attention on unmasked faults.
// Assumes a single request per cycle and single-cycle hw_fault pulses.
module fault_reg_bank
    import fbk_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_valid,
    input  logic                 cfg_write,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [DATA_W/8-1:0]  cfg_be,
    input  logic [DATA_W-1:0]    cfg_wdata,
    input  logic [DATA_W-1:0]    hw_fault,
    output logic                 rd_valid,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 attn,
    output logic                 unimpl,
    output logic                 size_err
);

    localparam int BE_W  = DATA_W / 8;
    localparam int OFS_W = $clog2(BE_W);
    localparam int IDX_W = ADDR_W - OFS_W;
    localparam logic [DATA_W-1:0] MODE_KEEP = {{8{1'b1}}, {(DATA_W-8){1'b0}}};
    localparam logic [DATA_W-1:0] RCTL_KEEP = {1'b1, {(DATA_W-1){1'b0}}};

    logic              acc_ok;
    logic [IDX_W-1:0]  idx;
    wr_dec_t           dec;
    logic [DATA_W-1:0] fault_q, mask_q, act0_q, act1_q;
    logic [DATA_W-1:0] first_q, mode_q, rstctl_q, rd_mux;

    assign acc_ok = cfg_valid && (&cfg_be) && (cfg_addr[OFS_W-1:0] == '0);
    assign idx    = cfg_addr[ADDR_W-1:OFS_W];

    fbk_decode #(.IDX_W(IDX_W)) u_dec (
        .wr_en (acc_ok && cfg_write),
        .idx   (idx),
        .dec   (dec)
    );

    fbk_alias_reg #(.W(DATA_W)) u_fault (
        .clk(clk), .rst_n(rst_n), .op(dec.fault_op),
        .wdata(cfg_wdata), .set_vec(hw_fault), .q(fault_q)
    );

    fbk_alias_reg #(.W(DATA_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .op(dec.mask_op),
        .wdata(cfg_wdata), .set_vec('0), .q(mask_q)
    );

    fbk_keep_reg #(.W(DATA_W), .KEEP('1)) u_act0 (
        .clk(clk), .rst_n(rst_n), .we(dec.act0_we), .wdata(cfg_wdata), .q(act0_q)
    );

    fbk_keep_reg #(.W(DATA_W), .KEEP('1)) u_act1 (
        .clk(clk), .rst_n(rst_n), .we(dec.act1_we), .wdata(cfg_wdata), .q(act1_q)
    );

    fbk_keep_reg #(.W(DATA_W), .KEEP(MODE_KEEP)) u_mode (
        .clk(clk), .rst_n(rst_n), .we(dec.mode_we), .wdata(cfg_wdata), .q(mode_q)
    );

    fbk_keep_reg #(.W(DATA_W), .KEEP(RCTL_KEEP)) u_rstctl (
        .clk(clk), .rst_n(rst_n), .we(dec.rstctl_we), .wdata(cfg_wdata), .q(rstctl_q)
    );

    fbk_first_err #(.W(DATA_W)) u_first (
        .clk(clk), .rst_n(rst_n), .clr(dec.first_clr), .pulse(hw_fault), .q(first_q)
    );

    assign attn = |(fault_q & ~mask_q);

    fbk_read_mux #(.W(DATA_W), .IDX_W(IDX_W)) u_rmux (
        .idx(idx), .fault(fault_q), .mask(mask_q), .act0(act0_q), .act1(act1_q),
        .first(first_q), .mode(mode_q), .rstctl(rstctl_q), .attn(attn), .data(rd_mux)
    );

    // Purpose: register read responses one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= cfg_valid && !cfg_write;
            if (cfg_valid && !cfg_write)
                rd_data <= acc_ok ? rd_mux : '1;
        end
    end

    // Purpose: raise one-cycle error flags for rejected requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unimpl   <= 1'b0;
            size_err <= 1'b0;
        end else begin
            unimpl   <= dec.unimpl;
            size_err <= cfg_valid && !acc_ok;
        end
    end

endmodule

// File: rtl/fbk_checker.sv
// Property checker for the fault register bank, attached by bind.
// Assumes the default index map from fbk_pkg.
module fbk_checker #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_valid,
    input logic                cfg_write,
    input logic [ADDR_W-1:0]   cfg_addr,
    input logic [DATA_W/8-1:0] cfg_be,
    input logic [DATA_W-1:0]   cfg_wdata,
    input logic [DATA_W-1:0]   hw_fault,
    input logic                attn,
    input logic                unimpl,
    input logic                size_err,
    input logic [DATA_W-1:0]   fault_q,
    input logic [DATA_W-1:0]   mask_q,
    input logic [DATA_W-1:0]   first_q
);

    logic          full_ok;
    logic          wr_ok;
    logic [ADDR_W-4:0] cidx;

    assign full_ok = cfg_valid && (&cfg_be) && (cfg_addr[2:0] == 3'd0);
    assign wr_ok   = full_ok && cfg_write;
    assign cidx    = cfg_addr[ADDR_W-1:3];

    a_r1_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_write && !full_ok && hw_fault == '0)
        |=> (fault_q == $past(fault_q) && mask_q == $past(mask_q)));

    a_r1_size_flag: assert property (@(posedge clk) disable iff (!rst_n)
        size_err |-> $past(cfg_valid && !full_ok));

    a_r3_clear_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && cidx == 1 && hw_fault == '0)
        |=> fault_q == ($past(fault_q) & $past(cfg_wdata)));

    a_r4_mask_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && cidx == 5) |=> mask_q == ($past(mask_q) | $past(cfg_wdata)));

    a_r6_first_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && cidx == 8 && hw_fault == '0) |=> first_q == '0);

    a_r9_pulse_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_fault != '0) |=> ((fault_q & $past(hw_fault)) == $past(hw_fault)));

    a_r10_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> !attn);

    a_r11_unimpl_flag: assert property (@(posedge clk) disable iff (!rst_n)
        unimpl |-> $past(wr_ok && cidx > 12));

endmodule

bind fault_reg_bank fbk_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .hw_fault(hw_fault), .attn(attn), .unimpl(unimpl), .size_err(size_err),
    .fault_q(fault_q), .mask_q(mask_q), .first_q(first_q)
);

// File: tb/fault_reg_bank_tb.sv
module fault_reg_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0;
    logic        cfg_write = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [7:0]  cfg_be = '0;
    logic [63:0] cfg_wdata = '0;
    logic [63:0] hw_fault = '0;
    logic        rd_valid, attn, unimpl, size_err;
    logic [63:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [63:0] m_fault, m_mask, m_act0, m_act1, m_first, m_mode, m_rctl;

    always #4 clk = ~clk;

    fault_reg_bank u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
        .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .hw_fault(hw_fault), .rd_valid(rd_valid), .rd_data(rd_data),
        .attn(attn), .unimpl(unimpl), .size_err(size_err)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic m_attn();
        return |(m_fault & ~m_mask);
    endfunction

    function automatic logic [63:0] m_read(input int idx);
        case (idx)
            0, 1, 2:  return m_fault;
            3, 4, 5:  return m_mask;
            6:        return m_act0;
            7:        return m_act1;
            8:        return m_first;
            9:        return m_mode;
            10:       return m_rctl;
            11:       return m_fault & ~m_mask;
            12:       return {m_attn(), (m_first != 0), 62'd0};
            default:  return 64'd0;
        endcase
    endfunction

    // Model of one accepted write plus pulse, applied after the clock edge.
    task automatic m_write(input int idx, input logic [63:0] d, input bit ok, input logic [63:0] hw);
        logic [63:0] f;
        f = m_fault;
        if (ok) begin
            case (idx)
                0: f = d;
                1: f = m_fault & d;
                2: f = m_fault | d;
                3: m_mask = d;
                4: m_mask = m_mask & d;
                5: m_mask = m_mask | d;
                6: m_act0 = d;
                7: m_act1 = d;
                9: m_mode = d & 64'hFF00_0000_0000_0000;
                10: m_rctl = d & 64'h8000_0000_0000_0000;
                default: ;
            endcase
        end
        m_fault = f | hw;
        if (m_first == 0 && hw != 0) m_first = hw;
        else if (ok && idx == 8)     m_first = 0;
    endtask

    task automatic do_write(input int idx, input logic [63:0] d, input logic [7:0] be,
                            input logic [2:0] ofs, input logic [63:0] hw);
        bit ok;
        ok = (be == 8'hFF) && (ofs == 3'd0);
        cfg_valid = 1'b1; cfg_write = 1'b1;
        cfg_addr  = 12'((idx << 3) | ofs);
        cfg_be = be; cfg_wdata = d; hw_fault = hw;
        @(negedge clk);
        m_write(idx, d, ok, hw);
        cfg_valid = 1'b0; cfg_write = 1'b0; hw_fault = '0;
        check(attn == m_attn(), "R10 attn after write", 64'(attn), 64'(m_attn()));
        check(size_err == !ok, "R1 size_err flag", 64'(size_err), 64'(!ok));
        check(unimpl == (ok && idx > 12), "R11 unimpl flag", 64'(unimpl), 64'(ok && idx > 12));
    endtask

    task automatic do_read(input int idx, input logic [7:0] be, input string tag);
        logic [63:0] exp;
        exp = (be == 8'hFF) ? m_read(idx) : 64'hFFFF_FFFF_FFFF_FFFF;
        cfg_valid = 1'b1; cfg_write = 1'b0;
        cfg_addr = 12'(idx << 3); cfg_be = be;
        @(negedge clk);
        cfg_valid = 1'b0;
        check(rd_valid === 1'b1, "R12 rd_valid", 64'(rd_valid), 64'd1);
        check(rd_data === exp, tag, rd_data, exp);
    endtask

    initial begin
        m_fault = 0; m_mask = 0; m_act0 = 0; m_act1 = 0;
        m_first = 0; m_mode = 0; m_rctl = 0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        check(attn == 0 && rd_valid == 0 && unimpl == 0 && size_err == 0,
              "R13 outputs after reset", {attn, rd_valid, unimpl, size_err}, 0);
        for (int i = 0; i < 13; i++) do_read(i, 8'hFF, "R13 word zero after reset");

        // R2 replace, R3 aliases
        do_write(0, 64'hF0F0_0000_0000_00FF, 8'hFF, 0, 0);
        do_read(0, 8'hFF, "R2 fault replace");
        do_write(1, 64'hFFFF_0000_0000_000F, 8'hFF, 0, 0);
        do_read(1, 8'hFF, "R3 fault clear alias");
        do_write(2, 64'h0000_0000_0001_0000, 8'hFF, 0, 0);
        do_read(2, 8'hFF, "R3 fault set alias");
        // R4 mask aliases, R10 full mask clears attn
        do_write(3, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 0, 0);
        check(attn == 0, "R10 attn with full mask", 64'(attn), 0);
        do_write(4, 64'h0FFF_FFFF_FFFF_FFFF, 8'hFF, 0, 0);
        do_read(3, 8'hFF, "R4 mask clear alias");
        do_write(5, 64'h1000_0000_0000_0000, 8'hFF, 0, 0);
        do_read(5, 8'hFF, "R4 mask set alias");
        // R5 action words
        do_write(6, 64'hDEAD_BEEF_0123_4567, 8'hFF, 0, 0);
        do_write(7, 64'h89AB_CDEF_FEDC_BA98, 8'hFF, 0, 0);
        do_read(6, 8'hFF, "R5 action0");
        do_read(7, 8'hFF, "R5 action1");
        // R7 kept bits
        do_write(9, '1, 8'hFF, 0, 0);
        do_read(9, 8'hFF, "R7 mode keeps top byte");
        do_write(10, '1, 8'hFF, 0, 0);
        do_read(10, 8'hFF, "R7 reset control keeps bit 63");
        // R8 view words ignore writes
        do_write(11, '1, 8'hFF, 0, 0);
        do_write(12, '1, 8'hFF, 0, 0);
        do_read(11, 8'hFF, "R8 unmasked view");
        do_read(12, 8'hFF, "R8 status view");
        // R9 pulse against replace-with-zero
        do_write(0, 64'd0, 8'hFF, 0, 64'h0000_0000_0000_0100);
        do_read(0, 8'hFF, "R9 pulse wins over replace");
        do_read(8, 8'hFF, "R6 first error captured");
        // R6 clear with capture-wins collision
        do_write(8, 64'd0, 8'hFF, 0, 64'h0000_0000_0000_0200);
        do_read(8, 8'hFF, "R6 nonempty clear beats pulse");
        do_write(8, 64'h5, 8'hFF, 0, 64'h0000_0000_0000_0400);
        do_read(8, 8'hFF, "R6 capture into empty beats clear");
        // R1 rejected accesses
        do_write(0, '1, 8'h7F, 0, 0);
        do_write(3, 64'd0, 8'hFF, 3'd4, 0);
        do_read(0, 8'hFF, "R1 partial write dropped");
        do_read(3, 8'hFF, "R1 misaligned write dropped");
        do_read(0, 8'h0F, "R1 partial read all ones");
        // R11 unimplemented
        do_write(20, '1, 8'hFF, 0, 0);
        do_read(20, 8'hFF, "R11 unimplemented read zero");
        for (int i = 0; i < 13; i++) do_read(i, 8'hFF, "R11 state unchanged");

        // Random mix
        for (int n = 0; n < 600; n++) begin
            int idx;
            logic [63:0] d, hw;
            logic [7:0] be;
            idx = int'($urandom_range(0, 15));
            d   = {$urandom, $urandom};
            hw  = ($urandom_range(0, 3) == 0) ? (64'd1 << $urandom_range(0, 63)) : 64'd0;
            be  = ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'hFF;
            do_write(idx, d, be, 0, hw);
            do_read(int'($urandom_range(0, 14)), 8'hFF, "R12 random read-back");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule